// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer takes one warp-wide global memory request and turns it into the fewest cache-block transactions needed to serve it. Each of the 32 lanes presents its own byte address and a valid bit, and the whole request carries a single load/store flag. Lanes whose addresses fall in the same 128-byte block are merged into one transaction. For each transaction the block drives the block-aligned address, the mask of lanes it serves, and a 4-bit mask of the 32-byte sectors those lanes actually touch. The sector mask lets the downstream memory system fetch only DRAM-sized pieces instead of whole lines.

Issue is ordered and takes one transaction per cycle. The lowest-numbered lane that is still pending chooses the block. Every other pending lane in that block joins the transaction and is removed from the pending set once the transaction is accepted. The transaction output uses a valid/ready handshake, and while ready is low nothing changes. A new request is taken only while the block is idle. A one-cycle done pulse follows the acceptance of the final transaction.

The control is a three-state machine:
- **IDLE**: `req_ready` is high.
- **ISSUE**: `txn_valid` is high.
- **DONE**: `done` is high.

Its transitions are:
- *accept*: IDLE to ISSUE, on a request with at least one active lane.
- *empty accept*: IDLE to DONE, on a request with no active lane.
- *last accept*: ISSUE to DONE, when the accepted transaction leaves no pending lane.
- *return*: DONE to IDLE, unconditionally.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `req_ready` is 1, `txn_valid` is 0 and `done` is 0.
- R2: A lane's block is address bits [31:7]. All pending lanes whose block equals the leader's block are served by one transaction, and `txn_addr` is that block with bits [6:0] zero.
- R3: The lowest-numbered pending lane is the leader. Transactions therefore leave in increasing order of leader lane, and `txn_lanes` bit i marks lane i as served.
- R4: `txn_sectors` bit s is 1 exactly when some served lane has address bits [6:5] equal to s.
- R5: A lane whose valid bit is 0 never appears in `txn_lanes` and never causes a transaction. A request with all valid bits 0 produces no transaction and goes straight to done.
- R6: While `txn_valid` is 1 and `txn_ready` is 0, `txn_addr`, `txn_lanes` and `txn_sectors` hold their values and `txn_valid` stays 1.
- R7: Each active lane is served by exactly one transaction. `done` is 1 for exactly one cycle, in the cycle after the last transaction is accepted, or in the cycle after an empty request is accepted.
- R8: `req_ready` is 1 only in IDLE. A `req_valid` presented while busy is ignored and does not disturb the request in progress.
- R9: Eight lanes reading consecutive 4-byte words from address 0 give exactly one transaction, with lanes mask 0xFF and sector mask 0001.
- R10: `txn_store` equals the load/store flag captured with the request, on every transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Warp request present |
| req_ready | output | 1 | Block idle; request taken on valid and ready |
| req_mask | input | 32 | Per-lane valid bits |
| req_addr | input | 1024 | Per-lane byte addresses, lane i at bits [32i+31:32i] |
| req_store | input | 1 | 1 = store, 0 = load |
| txn_valid | output | 1 | Transaction available |
| txn_ready | input | 1 | Downstream accepts the transaction |
| txn_addr | output | 32 | Block-aligned address |
| txn_sectors | output | 4 | Touched 32-byte sectors of the block |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_store | output | 1 | Load/store flag of the request |
| done | output | 1 | One-cycle pulse: request fully issued |

## Verification
The bench sweeps these corner cases:
- **Access shapes**: unit-stride words, 32-byte and 128-byte strides, descending addresses and pseudo-random warps confined to eight blocks. In each case a wrong merge rule splits or fuses blocks, and a wrong leader choice reorders the transactions against the arithmetic model.
- **Inactive lanes**: their addresses are placed in blocks of their own, so a design that ignores the valid bits emits extra transactions. An empty warp shows whether done arrives without any issue.
- **Backpressure**: alternating and sparse ready patterns catch a design that clears pending lanes or moves its outputs without a handshake.
- **Busy requests**: a conflicting request held valid while the block is busy catches a design that re-latches in mid-flight.
- **Done timing**: it is checked to the cycle, which catches an early, late or stretched pulse.

// File: rtl/wcoal_pkg.sv
package wcoal_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } wc_state_e;
endpackage

// File: rtl/wcoal_leader.sv
// Picks the lowest-numbered pending lane.
module wcoal_leader #(
    parameter int LANES = 32,
    parameter int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pending,
    output logic [IDX_W-1:0] idx,
    output logic             found
);
    always_comb begin
        idx   = '0;
        found = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                idx   = IDX_W'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wcoal_matcher.sv
// Per-lane block compare and sector collection.
module wcoal_matcher #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 7,
    parameter int SEC_W  = 5,
    parameter int NSEC   = 4,
    parameter int BLK_W  = ADDR_W - OFF_W,
    parameter int SIDX_W = OFF_W - SEC_W
) (
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic [LANES-1:0]        pending,
    input  logic [BLK_W-1:0]        lead_blk,
    output logic [LANES-1:0]        hit,
    output logic [NSEC-1:0]         sectors
);
    logic [NSEC-1:0] lane_sec [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BLK_W-1:0] blk;
        assign blk         = addr[g*ADDR_W+OFF_W +: BLK_W];
        assign hit[g]      = pending[g] && (blk == lead_blk);
        assign lane_sec[g] = NSEC'(1) << addr[g*ADDR_W+SEC_W +: SIDX_W];
    end

    always_comb begin
        sectors = '0;
        for (int i = 0; i < LANES; i++) begin
            if (hit[i]) sectors = sectors | lane_sec[i];
        end
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import wcoal_pkg::*;
#(
    parameter int LANES        = 32,
    parameter int ADDR_W       = 32,
    parameter int BLOCK_BYTES  = 128,
    parameter int SECTOR_BYTES = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [LANES-1:0]        req_mask,
    input  logic [LANES*ADDR_W-1:0] req_addr,
    input  logic                    req_store,
    output logic                    txn_valid,
    input  logic                    txn_ready,
    output logic [ADDR_W-1:0]       txn_addr,
    output logic [BLOCK_BYTES/SECTOR_BYTES-1:0] txn_sectors,
    output logic [LANES-1:0]        txn_lanes,
    output logic                    txn_store,
    output logic                    done
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int SEC_W = $clog2(SECTOR_BYTES);
    localparam int NSEC  = BLOCK_BYTES / SECTOR_BYTES;
    localparam int IDX_W = $clog2(LANES);
    localparam int BLK_W = ADDR_W - OFF_W;

    wc_state_e state_q, state_d;

    logic [LANES*ADDR_W-1:0] addr_q;
    logic [LANES-1:0]        mask_q;
    logic [LANES-1:0]        pending_q;
    logic                    store_q;

    logic [IDX_W-1:0]  lead_idx;
    logic              lead_found;
    logic [ADDR_W-1:0] lead_addr;
    logic [BLK_W-1:0]  lead_blk;
    logic [LANES-1:0]  hit;
    logic [NSEC-1:0]   sectors;
    logic [LANES-1:0]  remaining;
    logic              accept_req;
    logic              accept_txn;

    wcoal_leader #(.LANES(LANES), .IDX_W(IDX_W)) u_leader (
        .pending (pending_q),
        .idx     (lead_idx),
        .found   (lead_found)
    );

    assign lead_addr = addr_q[lead_idx*ADDR_W +: ADDR_W];
    assign lead_blk  = lead_addr[ADDR_W-1:OFF_W];

    wcoal_matcher #(
        .LANES(LANES), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
        .SEC_W(SEC_W), .NSEC(NSEC)
    ) u_matcher (
        .addr     (addr_q),
        .pending  (pending_q),
        .lead_blk (lead_blk),
        .hit      (hit),
        .sectors  (sectors)
    );

    assign remaining  = pending_q & ~hit;
    assign accept_req = req_valid && (state_q == ST_IDLE);
    assign accept_txn = txn_ready && (state_q == ST_ISSUE) && lead_found;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = (req_mask == '0) ? ST_DONE : ST_ISSUE;
            end
            ST_ISSUE: begin
                if (accept_txn && remaining == '0) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture and pending tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            mask_q    <= '0;
            pending_q <= '0;
            store_q   <= 1'b0;
        end else if (accept_req) begin
            addr_q    <= req_addr;
            mask_q    <= req_mask;
            pending_q <= req_mask;
            store_q   <= req_store;
        end else if (accept_txn) begin
            pending_q <= remaining;
        end
    end

    // Outputs
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        txn_valid   = (state_q == ST_ISSUE);
        done        = (state_q == ST_DONE);
        txn_addr    = {lead_blk, OFF_W'(0)};
        txn_lanes   = hit;
        txn_sectors = sectors;
        txn_store   = store_q;
    end

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr)
            && $stable(txn_lanes) && $stable(txn_sectors));

    assert_active_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> (txn_lanes & ~mask_q) == '0);

    assert_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_lanes != '0 && txn_sectors != '0);

    assert_leader_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |-> txn_lanes[lead_idx]
            && (pending_q & ~({LANES{1'b1}} << lead_idx)) == '0);

    assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && txn_ready && (pending_q & ~txn_lanes) == '0 |=> done);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready);

    assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/warp_coalescer_bench.sv
module warp_coalescer_bench;
    localparam int LANES = 32;
    localparam int AW    = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst_n;
    logic                 req_valid;
    logic                 req_ready;
    logic [LANES-1:0]     req_mask;
    logic [LANES*AW-1:0]  req_addr;
    logic                 req_store;
    logic                 txn_valid;
    logic                 txn_ready;
    logic [AW-1:0]        txn_addr;
    logic [3:0]           txn_sectors;
    logic [LANES-1:0]     txn_lanes;
    logic                 txn_store;
    logic                 done;

    warp_coalescer u_warp_coalescer (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_mask(req_mask), .req_addr(req_addr), .req_store(req_store),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_addr(txn_addr), .txn_sectors(txn_sectors),
        .txn_lanes(txn_lanes), .txn_store(txn_store), .done(done)
    );

    int checks = 0;
    int errors = 0;

    logic [31:0] wa      [LANES];
    logic [31:0] ex_addr [LANES];
    logic [31:0] ex_lanes[LANES];
    logic [3:0]  ex_sec  [LANES];
    int          n_exp;

    task automatic chk(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Arithmetic model: leader = lowest pending lane, merge same block.
    task automatic model(input logic [31:0] m);
        logic [31:0] pend;
        logic [31:0] blk;
        logic [31:0] ln;
        logic [3:0]  sc;
        int          ld;
        pend  = m;
        n_exp = 0;
        while (pend != 0) begin
            ld = 0;
            for (int i = LANES - 1; i >= 0; i--) if (pend[i]) ld = i;
            blk = wa[ld] & 32'hFFFF_FF80;
            ln  = '0;
            sc  = '0;
            for (int i = 0; i < LANES; i++) begin
                if (pend[i] && ((wa[i] & 32'hFFFF_FF80) == blk)) begin
                    ln[i] = 1'b1;
                    sc[wa[i][6:5]] = 1'b1;
                end
            end
            ex_addr[n_exp]  = blk;
            ex_lanes[n_exp] = ln;
            ex_sec[n_exp]   = sc;
            pend = pend & ~ln;
            n_exp++;
        end
    endtask

    task automatic run_warp(input logic [31:0] m, input logic st,
                            input int mode, input bit poke, input string tag);
        int          got;
        int          cyc;
        bit          stall;
        logic [31:0] pa;
        logic [31:0] pl;
        logic [3:0]  ps;
        model(m);
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R8 ready when idle"}, req_ready, 1);
        req_valid = 1'b1;
        req_mask  = m;
        req_store = st;
        for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = wa[i];
        @(negedge clk);
        req_valid = poke;
        if (poke) begin
            req_mask  = ~m;
            req_store = ~st;
            for (int i = 0; i < LANES; i++)
                req_addr[i*AW +: AW] = 32'hDEAD_0000 ^ (i << 7);
        end
        got   = 0;
        stall = 1'b0;
        pa = '0; pl = '0; ps = '0;
        for (cyc = 0; cyc < 400; cyc++) begin
            if (got == n_exp) begin
                chk(done === 1'b1 && txn_valid === 1'b0,
                    {tag, " R7 done right after last accept"},
                    {done, txn_valid}, 2'b10);
                break;
            end
            chk(done === 1'b0, {tag, " R7 no early done"}, done, 0);
            chk(req_ready === 1'b0, {tag, " R8 not ready while busy"}, req_ready, 0);
            chk(txn_valid === 1'b1, {tag, " R3 issue continues"}, txn_valid, 1);
            if (stall)
                chk(txn_addr === pa && txn_lanes === pl && txn_sectors === ps,
                    {tag, " R6 held while stalled"}, {txn_addr, txn_lanes}, {pa, pl});
            chk(txn_addr === ex_addr[got], {tag, " R2 block address"}, txn_addr, ex_addr[got]);
            chk(txn_lanes === ex_lanes[got], {tag, " R3 R5 lanes served"}, txn_lanes, ex_lanes[got]);
            chk(txn_sectors === ex_sec[got], {tag, " R4 sector mask"}, txn_sectors, ex_sec[got]);
            chk(txn_store === st, {tag, " R10 store flag"}, txn_store, st);
            case (mode)
                0:       txn_ready = 1'b1;
                1:       txn_ready = cyc[0];
                default: txn_ready = (cyc % 3 == 2);
            endcase
            stall = !txn_ready;
            pa = txn_addr; pl = txn_lanes; ps = txn_sectors;
            if (txn_ready) got++;
            @(negedge clk);
            txn_ready = 1'b0;
        end
        if (cyc >= 400) chk(1'b0, {tag, " R7 request never completed"}, got, n_exp);
        req_valid = 1'b0;
        @(negedge clk);
        chk(done === 1'b0 && req_ready === 1'b1,
            {tag, " R7 single-cycle done then idle"}, {done, req_ready}, 2'b01);
    endtask

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] msk;
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_mask  = '0;
        req_addr  = '0;
        req_store = 1'b0;
        txn_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0,
            "R1 reset state", {req_ready, txn_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready === 1'b1 && txn_valid === 1'b0 && done === 1'b0,
            "R1 state after reset release", {req_ready, txn_valid, done}, 3'b100);

        // R9: eight consecutive words from 0
        for (int i = 0; i < LANES; i++) wa[i] = i * 4;
        model(32'h0000_00FF);
        chk(n_exp == 1 && ex_sec[0] == 4'b0001, "R9 model sanity", n_exp, 1);
        run_warp(32'h0000_00FF, 1'b0, 0, 1'b0, "R9 eight words");

        // Full warp unit stride at an aligned base
        for (int i = 0; i < LANES; i++) wa[i] = 32'h1000 + i * 4;
        run_warp(32'hFFFF_FFFF, 1'b1, 1, 1'b1, "unit stride");

        // 128-byte stride: one transaction per lane
        for (int i = 0; i < LANES; i++) wa[i] = 32'h2_0000 + i * 128;
        run_warp(32'hFFFF_FFFF, 1'b0, 2, 1'b1, "stride128");

        // 32-byte stride: four lanes per block, all sectors
        for (int i = 0; i < LANES; i++) wa[i] = 32'h4000 + i * 32;
        run_warp(32'hFFFF_FFFF, 1'b1, 0, 1'b0, "stride32");

        // Descending addresses: order follows lane number
        for (int i = 0; i < LANES; i++) wa[i] = (31 - i) * 64 + 8;
        run_warp(32'hFFFF_FFFF, 1'b0, 1, 1'b0, "R3 descending");

        // R5: inactive lanes sit in their own blocks
        for (int i = 0; i < LANES; i++) wa[i] = i[0] ? 32'h8000 + i * 128 : 32'h40;
        run_warp(32'h5555_5555, 1'b1, 0, 1'b1, "R5 inactive lanes");

        // R5: empty request
        run_warp(32'h0, 1'b0, 0, 1'b1, "R5 empty");

        // Single top lane
        for (int i = 0; i < LANES; i++) wa[i] = 32'h7FFF_FFE0;
        run_warp(32'h8000_0000, 1'b1, 2, 1'b0, "single lane31");

        // Pseudo-random sweep confined to eight blocks
        seed = 32'h1234_5678;
        for (int w = 0; w < 48; w++) begin
            for (int i = 0; i < LANES; i++) begin
                seed  = step(seed);
                wa[i] = 32'h0010_0000 | (seed & 32'h0000_03FC);
            end
            seed = step(seed);
            msk  = (w % 4 == 0) ? 32'hFFFF_FFFF : seed;
            run_warp(msk, seed[3], w % 3, w[0], "random sweep");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule